// File: doc/BRIEF.md
# Maskable Interrupt Priority Arbiter

The arbiter holds one sticky pending flag and one 3-bit priority field for each of a parameterised number of maskable interrupt sources. A one-cycle pulse on a source's request line marks it pending. Each cycle the block picks, from the pending sources, the one that should be taken next. A source is eligible only when three things hold: the processor-wide enable is 1, its pending flag is set, and its priority field is strictly greater than the current processor priority level.

The selected source is presented combinationally on `irq_valid`, `irq_idx` and `irq_level`. When the core takes it, the core raises `irq_ack` for one cycle and the block clears that source's flag.

Software reaches the block through a single write port. With `wr_sel` = 0, the write loads a priority field. With `wr_sel` = 1, the write targets a pending flag; that flag can only be cleared, never set. The enable flag and the priority level are plain inputs owned by the core.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset all pending flags and all priority fields are 0, so `irq_valid` stays low even with `gie_i` = 1 and `ipl_i` = 0.
- R2: A 1 on `req_i[k]` at a clock edge sets flag k from the next cycle. The flag stays set while the source is disabled or outranked, until it is cleared.
- R3: While `gie_i` = 0, `irq_valid` is 0 whatever flags and levels are present.
- R4: A pending source is eligible only if its level is strictly greater than `ipl_i`. Level 0 is never eligible, and `ipl_i` = 7 blocks every source.
- R5: Among eligible sources, the highest level wins. On equal levels, the lowest index wins.
- R6: `irq_ack` = 1 while `irq_valid` = 1 clears the flag of the source on `irq_idx` at that edge. Other flags are left unchanged.
- R7: If a source's request arrives at the same edge as its own acknowledge or software clear, its flag stays set.
- R8: A write with `wr_sel` = 1 and `wr_data[0]` = 0 clears flag `wr_addr`. A write with `wr_sel` = 1 and `wr_data[0]` = 1 leaves the flag unchanged.
- R9: A write with `wr_sel` = 0 loads `wr_data` into priority field `wr_addr` and never changes any flag. A flag write never changes any priority field.
- R10: While `irq_valid` = 1, `irq_level` equals the priority field of the source on `irq_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NSRC | Per-source request pulses |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | 0: priority field, 1: pending flag |
| wr_addr | input | clog2(NSRC) | Source index of the write |
| wr_data | input | LVL_W | Level value, or bit 0 = flag value |
| gie_i | input | 1 | Processor-wide maskable interrupt enable |
| ipl_i | input | LVL_W | Processor priority level |
| irq_valid | output | 1 | An eligible source exists |
| irq_idx | output | clog2(NSRC) | Index of the selected source |
| irq_level | output | LVL_W | Level of the selected source |
| irq_ack | input | 1 | Core takes the selected source |

## Verification
Pending flags and priority fields can only be seen through the selection outputs, which are combinational. A corrupted flag or field therefore shows up on `irq_valid`, `irq_idx` or `irq_level` in the very cycle after the edge that corrupted it, provided the bench has set `gie_i` and `ipl_i` so that the source is eligible. Opening the enable and lowering the priority level after each stimulus turns every hidden flag into a visible winner. Acknowledging the winners one by one then reveals the rest of the pending set in priority order.

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          req_i,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [$clog2(NSRC)-1:0]  wr_addr,
  input  logic [LVL_W-1:0]         wr_data,
  input  logic                     gie_i,
  input  logic [LVL_W-1:0]         ipl_i,
  output logic                     irq_valid,
  output logic [$clog2(NSRC)-1:0]  irq_idx,
  output logic [LVL_W-1:0]         irq_level,
  input  logic                     irq_ack
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  pend_q;
  logic [LVL_W-1:0] lvl_q [NSRC];
  logic [NSRC-1:0]  qual, ack_hit, sw_clr, lvl_we;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign qual[i]    = gie_i && pend_q[i] && (lvl_q[i] > ipl_i);
    assign ack_hit[i] = irq_ack && irq_valid && (irq_idx == IDX_W'(i));
    assign sw_clr[i]  = wr_en && wr_sel && (wr_addr == IDX_W'(i)) && !wr_data[0];
    assign lvl_we[i]  = wr_en && !wr_sel && (wr_addr == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        pend_q[i] <= 1'b0;
      else if (req_i[i])                 pend_q[i] <= 1'b1;
      else if (ack_hit[i] || sw_clr[i])  pend_q[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lvl_q[i] <= '0;
      else if (lvl_we[i]) lvl_q[i] <= wr_data;
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[i] |=> pend_q[i]);
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[i] && !req_i[i]) |=> !pend_q[i]);
    p_one_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[i] && !req_i[i] && wr_en && wr_sel && wr_addr == IDX_W'(i)) |=> !pend_q[i]);
    p_lvl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_we[i] |=> $stable(lvl_q[i]));
    p_lvl_write_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_we[i] && !req_i[i] && !ack_hit[i]) |=> pend_q[i] == $past(pend_q[i]));
  end

  always_comb begin
    irq_valid = 1'b0;
    irq_idx   = '0;
    irq_level = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && lvl_q[i] > irq_level) begin
        irq_valid = 1'b1;
        irq_idx   = IDX_W'(i);
        irq_level = lvl_q[i];
      end
    end
  end

  p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> gie_i);
  p_above_ipl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level > ipl_i);
  p_level_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level == lvl_q[irq_idx]);
  p_single_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit));
endmodule

// File: tb/tb_irq_prio_arb.sv
module tb_irq_prio_arb;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_i = '0;
  logic wr_en = 0, wr_sel = 0, gie_i = 0, irq_ack = 0;
  logic [2:0] wr_addr = '0, wr_data = '0, ipl_i = '0;
  logic irq_valid;
  logic [2:0] irq_idx, irq_level;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  irq_prio_arb #(.NSRC(N), .LVL_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .gie_i(gie_i), .ipl_i(ipl_i),
    .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_level(irq_level), .irq_ack(irq_ack));

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic expect_win(string tag, int idx, int lvl);
    chk({tag, " valid"}, irq_valid, 1);
    chk({tag, " idx"}, irq_idx, idx);
    chk({tag, " level"}, irq_level, lvl);
  endtask

  task automatic pulse(logic [N-1:0] m);
    req_i = m; @(negedge clk); req_i = '0;
  endtask

  task automatic wr(logic sel, int a, int d);
    wr_en = 1; wr_sel = sel; wr_addr = 3'(a); wr_data = 3'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ack();
    irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic t_reset;
    gie_i = 1; ipl_i = 0; #1;
    chk("R1 idle after reset", irq_valid, 0);
  endtask

  task automatic t_sticky;
    wr(0, 2, 3);
    gie_i = 0;
    pulse(8'b0000_0100);
    chk("R3 gie off", irq_valid, 0);
    @(negedge clk);
    gie_i = 1; #1;
    expect_win("R2 sticky", 2, 3);
    ipl_i = 3; #1;
    chk("R4 equal to ipl", irq_valid, 0);
    ipl_i = 2; #1;
    expect_win("R4 above ipl R10", 2, 3);
    ipl_i = 0;
  endtask

  task automatic t_level0;
    pulse(8'b0010_0000);
    expect_win("R4 level0 masked", 2, 3);
    ack();
    chk("R6 cleared, level0 hidden", irq_valid, 0);
    wr(0, 5, 1);
    expect_win("R9 level write keeps flag R2", 5, 1);
    ack();
    chk("R6 empty", irq_valid, 0);
  endtask

  task automatic t_arb;
    wr(0, 1, 4); wr(0, 3, 6); wr(0, 6, 6);
    pulse(8'b0100_1010);
    expect_win("R5 tie low index", 3, 6);
    ack();
    expect_win("R6 others kept R5", 6, 6);
    ack();
    expect_win("R5 next level", 1, 4);
    ack();
    chk("R6 all taken", irq_valid, 0);
  endtask

  task automatic t_ipl7;
    wr(0, 0, 7);
    pulse(8'b0000_0001);
    ipl_i = 7; #1;
    chk("R4 ipl7 blocks", irq_valid, 0);
    ipl_i = 6; #1;
    expect_win("R4 ipl6 admits 7", 0, 7);
    ack();
    ipl_i = 0; #1;
    chk("R6 ipl7 src cleared", irq_valid, 0);
  endtask

  task automatic t_sw;
    wr(0, 4, 5);
    pulse(8'b0001_0000);
    wr(1, 4, 1);
    expect_win("R8 write1 ignored", 4, 5);
    wr(1, 4, 0);
    chk("R8 write0 clears", irq_valid, 0);
    wr(1, 4, 1);
    chk("R8 write1 does not set", irq_valid, 0);
    pulse(8'b0001_0000);
    expect_win("R9 flag write kept level", 4, 5);
  endtask

  task automatic t_same;
    irq_ack = 1; req_i = 8'b0001_0000;
    @(negedge clk);
    irq_ack = 0; req_i = '0;
    expect_win("R7 req beats ack", 4, 5);
    req_i = 8'b0001_0000; wr_en = 1; wr_sel = 1; wr_addr = 4; wr_data = 0;
    @(negedge clk);
    req_i = '0; wr_en = 0;
    expect_win("R7 req beats sw clear", 4, 5);
    ack();
    chk("R6 final clear", irq_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_sticky;
    t_level0;
    t_arb;
    t_ipl7;
    t_sw;
    t_same;
    gie_i = 0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule